// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run side by side. The local component keeps a short outcome history for each branch, selected by a fold of the fetch address. That history then indexes a table of three-bit counters. The global component indexes a table of two-bit counters with a shift register holding the most recent branch directions. A third table of two-bit selector counters, indexed by the same global history, decides which component's answer is used.

The front end raises a request with the instruction word address. In the same cycle it reads back the prediction, plus the global and local histories that were used to form it. It keeps these two histories with the branch. When the branch resolves, the pipeline presents the outcome, the address, a mispredict flag and the two saved histories on the update port. The global history is advanced speculatively with every prediction. On a mispredict it is rebuilt from the saved copy.

Top module: `tourney_bp`

## Requirements
- R1: After reset, the global history is all zeros and every local history entry is all zeros. Global and selector counters start at the weakly-low value 01, and local counters start at 011. A reset block therefore predicts not-taken with pred_ghist = 0 and pred_lhist = 0.
- R2: A counter predicts taken when its most significant bit is 1. Training moves it by one toward the outcome, and it saturates at zero and at its all-ones value.
- R3: When the selector counter at the current global history has MSB 1, pred_taken is the global component's prediction. Otherwise it is the local component's prediction.
- R4: A request without a concurrent mispredict shifts pred_taken into bit 0 of the global history, so the next cycle pred_ghist = {old[W-2:0], pred_taken}. pred_ghist always shows the history before that shift.
- R5: An update with upd_mispredict = 1 sets the global history to {upd_ghist[W-2:0], upd_taken} on the next cycle. This overrides a request in the same cycle.
- R6: Each valid update shifts upd_taken into bit 0 of the local history entry selected by the XOR-fold of upd_pc. pred_lhist shows the entry selected by the XOR-fold of pred_pc. The fold XORs bit i of the address into index bit i mod LPC_W.
- R7: Each valid update trains the global counter at upd_ghist and the local counter at upd_lhist toward upd_taken. Both read their values from before the update.
- R8: A selector counter at upd_ghist is trained only when exactly one component was correct. It moves up when the global component was the correct one and down when the local one was.
- R9: With no request and no mispredict, the global history holds. An update without the mispredict flag does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_req | input | 1 | Prediction request; advances the global history |
| pred_pc | input | PC_W | Instruction word address being predicted |
| pred_taken | output | 1 | Predicted direction |
| pred_ghist | output | GHIST_W | Global history used for this prediction (checkpoint) |
| pred_lhist | output | LHIST_W | Local history used for this prediction |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | Word address of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_mispredict | input | 1 | Branch was mispredicted; rebuild global history |
| upd_ghist | input | GHIST_W | Global history checkpoint saved at prediction |
| upd_lhist | input | LHIST_W | Local history saved at prediction |

## Verification
The bench builds the block with an 8-bit address, a 4-bit global history, a 2-bit local index and 3-bit local histories. With these values the global and selector tables have 16 entries each, there are 4 history entries and 8 local counters. A few dozen updates therefore drive counters into both saturation ends. They also make several addresses alias onto one local history through the fold, and they flip selector counters both ways. Every cycle is compared against a reference model written in the bench. A pseudo-random phase exercises concurrent restore and request, as well as updates that hit the entry being read.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  // One saturating step of a w-bit counter toward up (1) or down (0).
  function automatic int sat_step(input int v, input logic up, input int w);
    int top_v;
    top_v = (1 << w) - 1;
    if (up) return (v >= top_v) ? top_v : v + 1;
    return (v <= 0) ? 0 : v - 1;
  endfunction

  // Weakly-not-taken value of a w-bit counter: 0111..1
  function automatic int weak_low(input int w);
    return (1 << (w - 1)) - 1;
  endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int CTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_dir,
  output logic             up_old_taken
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] INIT = CTR_W'(weak_low(CTR_W));

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] old_c;
  logic [CTR_W-1:0] new_c;

  always_comb begin
    old_c = mem[up_idx];
    new_c = CTR_W'(sat_step(int'(old_c), up_dir, CTR_W));
  end

  assign rd_taken     = mem[rd_idx][CTR_W-1];
  assign up_old_taken = old_c[CTR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (up_en) begin
      mem[up_idx] <= new_c;
    end
  end
endmodule

// File: rtl/tbp_lhist_table.sv
module tbp_lhist_table #(
  parameter int IDX_W = 10,
  parameter int H_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [H_W-1:0]   rd_hist,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [H_W-1:0] mem [DEPTH];

  assign rd_hist = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= {mem[wr_idx][H_W-2:0], wr_bit};
    end
  end
endmodule

// File: rtl/tbp_global_side.sv
module tbp_global_side
  import tbp_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int GCTR_W = 2,
  parameter int CCTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             g_taken,
  output logic             pick_global,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_taken,
  input  logic             up_local_right
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [GCTR_W-1:0] G_INIT = GCTR_W'(weak_low(GCTR_W));
  localparam logic [CCTR_W-1:0] C_INIT = CCTR_W'(weak_low(CCTR_W));

  logic [GCTR_W-1:0] gmem [DEPTH];
  logic [CCTR_W-1:0] cmem [DEPTH];
  logic [GCTR_W-1:0] g_old, g_new;
  logic [CCTR_W-1:0] c_old, c_new;
  logic              g_right, c_train;

  always_comb begin
    g_old   = gmem[up_idx];
    c_old   = cmem[up_idx];
    g_right = (g_old[GCTR_W-1] == up_taken);
    c_train = up_en && (g_right != up_local_right);
    g_new   = GCTR_W'(sat_step(int'(g_old), up_taken, GCTR_W));
    c_new   = CCTR_W'(sat_step(int'(c_old), g_right, CCTR_W));
  end

  assign g_taken     = gmem[rd_idx][GCTR_W-1];
  assign pick_global = cmem[rd_idx][CCTR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        gmem[i] <= G_INIT;
        cmem[i] <= C_INIT;
      end
    end else begin
      if (up_en)   gmem[up_idx] <= g_new;
      if (c_train) cmem[up_idx] <= c_new;
    end
  end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int PC_W    = 30,
  parameter int GHIST_W = 12,
  parameter int LPC_W   = 10,
  parameter int LHIST_W = 10,
  parameter int GCTR_W  = 2,
  parameter int LCTR_W  = 3,
  parameter int CCTR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pred_req,
  input  logic [PC_W-1:0]    pred_pc,
  output logic               pred_taken,
  output logic [GHIST_W-1:0] pred_ghist,
  output logic [LHIST_W-1:0] pred_lhist,
  input  logic               upd_valid,
  input  logic [PC_W-1:0]    upd_pc,
  input  logic               upd_taken,
  input  logic               upd_mispredict,
  input  logic [GHIST_W-1:0] upd_ghist,
  input  logic [LHIST_W-1:0] upd_lhist
);
  // Address bit i lands on index bit i mod LPC_W.
  function automatic logic [LPC_W-1:0] fold_pc(input logic [PC_W-1:0] pc);
    logic [LPC_W-1:0] r;
    r = '0;
    for (int i = 0; i < PC_W; i++) r[i % LPC_W] = r[i % LPC_W] ^ pc[i];
    return r;
  endfunction

  logic [GHIST_W-1:0] ghr;
  logic [LPC_W-1:0]   lht_rd_idx, lht_wr_idx;
  logic [LHIST_W-1:0] lh_now;
  logic               loc_taken, glob_taken, use_global;
  logic               l_old_taken, local_right, restore;

  assign lht_rd_idx  = fold_pc(pred_pc);
  assign lht_wr_idx  = fold_pc(upd_pc);
  assign local_right = (l_old_taken == upd_taken);
  assign restore     = upd_valid && upd_mispredict;

  tbp_lhist_table #(.IDX_W(LPC_W), .H_W(LHIST_W)) u_lht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lht_rd_idx), .rd_hist(lh_now),
    .wr_en(upd_valid), .wr_idx(lht_wr_idx), .wr_bit(upd_taken)
  );

  tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_lpt (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lh_now), .rd_taken(loc_taken),
    .up_en(upd_valid), .up_idx(upd_lhist), .up_dir(upd_taken),
    .up_old_taken(l_old_taken)
  );

  tbp_global_side #(.IDX_W(GHIST_W), .GCTR_W(GCTR_W), .CCTR_W(CCTR_W)) u_gsd (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghr), .g_taken(glob_taken), .pick_global(use_global),
    .up_en(upd_valid), .up_idx(upd_ghist), .up_taken(upd_taken),
    .up_local_right(local_right)
  );

  assign pred_taken = use_global ? glob_taken : loc_taken;
  assign pred_ghist = ghr;
  assign pred_lhist = lh_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ghr <= '0;
    else if (restore)  ghr <= {upd_ghist[GHIST_W-2:0], upd_taken};
    else if (pred_req) ghr <= {ghr[GHIST_W-2:0], pred_taken};
  end
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
  parameter int GHIST_W = 12,
  parameter int LHIST_W = 10,
  parameter int LPC_W   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pred_req,
  input logic               pred_taken,
  input logic [GHIST_W-1:0] pred_ghist,
  input logic [LHIST_W-1:0] pred_lhist,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic               upd_mispredict,
  input logic [GHIST_W-1:0] upd_ghist,
  input logic [LPC_W-1:0]   lht_rd_idx,
  input logic [LPC_W-1:0]   lht_wr_idx
);
  AST_SPEC_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_req && !(upd_valid && upd_mispredict)) |=>
      pred_ghist == {$past(pred_ghist[GHIST_W-2:0]), $past(pred_taken)}); // R4

  AST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_mispredict) |=>
      pred_ghist == {$past(upd_ghist[GHIST_W-2:0]), $past(upd_taken)}); // R5

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_req && !(upd_valid && upd_mispredict)) |=> $stable(pred_ghist)); // R9

  AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && lht_rd_idx == lht_wr_idx) |=>
      (lht_rd_idx != $past(lht_rd_idx)) ||
      pred_lhist == {$past(pred_lhist[LHIST_W-2:0]), $past(upd_taken)}); // R6
endmodule

bind tourney_bp tbp_checker #(.GHIST_W(GHIST_W), .LHIST_W(LHIST_W), .LPC_W(LPC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_taken(pred_taken),
  .pred_ghist(pred_ghist), .pred_lhist(pred_lhist), .upd_valid(upd_valid),
  .upd_taken(upd_taken), .upd_mispredict(upd_mispredict), .upd_ghist(upd_ghist),
  .lht_rd_idx(lht_rd_idx), .lht_wr_idx(lht_wr_idx)
);

// File: tb/sim_tourney_bp.sv
module sim_tourney_bp;
  localparam int PC_W = 8, GW = 4, LPW = 2, LHW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pred_req = 0, pred_taken;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic [GW-1:0] pred_ghist, upd_ghist = '0;
  logic [LHW-1:0] pred_lhist, upd_lhist = '0;
  logic upd_valid = 0, upd_taken = 0, upd_mispredict = 0;

  int total = 0, bad = 0;
  int mg[16], mc[16], ml[8], mh[4], mghr;

  always #2 clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .GHIST_W(GW), .LPC_W(LPW), .LHIST_W(LHW)) u0 (
    .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_ghist(pred_ghist), .pred_lhist(pred_lhist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_mispredict(upd_mispredict), .upd_ghist(upd_ghist), .upd_lhist(upd_lhist)
  );

  function automatic int fold(input int pc);
    int r = 0;
    for (int k = 0; k < PC_W; k += LPW) r ^= (pc >> k) & 3;
    return r;
  endfunction

  function automatic int bump(input int v, input bit up, input int mx);
    if (up && v < mx) return v + 1;
    if (!up && v > 0) return v - 1;
    return v;
  endfunction

  task automatic check(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic step(input bit req, input int pc, input bit uv, input int upc,
                      input bit ut, input bit um, input int ugh, input int ulh,
                      input string rq);
    int lh, et;
    bit gr, lr;
    @(negedge clk);
    pred_req = req; pred_pc = PC_W'(pc); upd_valid = uv; upd_pc = PC_W'(upc);
    upd_taken = ut; upd_mispredict = um; upd_ghist = GW'(ugh); upd_lhist = LHW'(ulh);
    #1;
    lh = mh[fold(pc)];
    et = (mc[mghr] >= 2) ? int'(mg[mghr] >= 2) : int'(ml[lh] >= 4);
    check(rq, "taken", int'(pred_taken), et);
    check(rq, "ghist", int'(pred_ghist), mghr);
    check(rq, "lhist", int'(pred_lhist), lh);
    if (uv) begin
      gr = (mg[ugh] >= 2) == ut;
      lr = (ml[ulh] >= 4) == ut;
      if (gr != lr) mc[ugh] = bump(mc[ugh], gr, 3);
      mg[ugh] = bump(mg[ugh], ut, 3);
      ml[ulh] = bump(ml[ulh], ut, 7);
      mh[fold(upc)] = ((mh[fold(upc)] << 1) | int'(ut)) & 7;
    end
    if (uv && um)  mghr = ((ugh << 1) | int'(ut)) & 15;
    else if (req)  mghr = ((mghr << 1) | et) & 15;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    check("R1", "ghist", int'(pred_ghist), 0);
    check("R1", "lhist", int'(pred_lhist), 0);
    check("R1", "taken", int'(pred_taken), 0);
    step(0, 8'h3c, 0, 0, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_spec;
    for (int i = 0; i < 6; i++) step(1, 8'h10 + 7 * i, 0, 0, 0, 0, 0, 0, "R4");
  endtask

  task automatic t_hold;
    step(0, 8'h11, 1, 8'h40, 1, 0, 9, 1, "R9");
    step(0, 8'h11, 1, 8'h41, 0, 0, 9, 1, "R9");
    step(0, 8'h11, 0, 0, 0, 0, 0, 0, "R9");
  endtask

  task automatic t_restore;
    step(1, 8'h22, 1, 8'h22, 1, 1, 4'b1011, 0, "R5");
    step(0, 8'h22, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 8'h22, 1, 8'h20, 0, 1, 4'b0110, 0, "R5");
    step(0, 8'h22, 0, 0, 0, 0, 0, 0, "R5");
  endtask

  task automatic t_local;
    for (int i = 0; i < 6; i++) step(0, 8'h05, 1, 8'h05, 1, 0, 3, 3'b010, "R2");
    step(0, 8'h05, 1, 8'h05, 0, 0, 3, 3'b010, "R2");
    step(0, 8'h50, 1, 8'h05, 1, 0, 7, 3'b111, "R6");
    step(0, 8'h05, 1, 8'h14, 1, 0, 7, 3'b111, "R6");
    step(1, 8'h05, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 8'h05, 0, 0, 0, 0, 0, 0, "R7");
  endtask

  task automatic t_choice;
    step(0, 8'h05, 1, 8'h33, 0, 0, 2, 3'b101, "R8");
    step(0, 8'h05, 1, 8'h33, 0, 0, 2, 3'b010, "R8");
    step(0, 8'h05, 1, 8'h33, 0, 0, 2, 3'b010, "R8");
    step(1, 8'h05, 1, 8'h33, 0, 1, 4'b0001, 0, "R3");
    step(0, 8'h05, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 8'h05, 1, 8'h33, 1, 0, 2, 3'b101, "R8");
    step(0, 8'h05, 1, 8'h33, 1, 0, 2, 3'b101, "R8");
    step(0, 8'h05, 0, 0, 0, 0, 0, 0, "R3");
  endtask

  task automatic t_stress;
    logic [15:0] lf = 16'hace1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], int'(lf[15:8]), lf[1], int'(lf[9:2]), lf[3], lf[4] & lf[5],
           int'(lf[13:10]), int'(lf[7:5]), "R7");
    end
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mg[i] = 1; mc[i] = 1; end
    for (int i = 0; i < 8; i++) ml[i] = 3;
    for (int i = 0; i < 4; i++) mh[i] = 0;
    mghr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_spec;
    t_hold;
    t_restore;
    t_local;
    t_choice;
    t_stress;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule